// File: doc/BRIEF.md
# Ready latency decrease adapter

This block joins an upstream producer that reacts to backpressure one cycle late to a downstream consumer that uses plain valid/ready handshaking. On the sink side the producer looks at `snk_ready` of the previous cycle: a beat offered in cycle t is legal only if `snk_ready` was high in cycle t-1, and the block takes every legal beat without exception. On the source side a beat moves in a cycle where `src_valid` and `src_ready` are both high.

A two-slot store absorbs the beats that are still on their way when the consumer stalls. When the store is empty, an incoming beat falls through to the output in the same cycle, so a consumer that never stalls sees one beat per clock with no extra latency. `snk_ready` is a register. It is computed from the fill level after the edge plus the one beat that may still be in flight. A control state machine tracks the fill level in three states: `FILL_NONE`, `FILL_ONE` and `FILL_TWO`. Its transitions are named as follows:
- `LOAD`: NONE to ONE, a beat arrives and is not taken.
- `FILL`: ONE to TWO, a beat arrives and nothing leaves.
- `DRAIN`: ONE to NONE, or TWO to ONE, a beat leaves and none arrives.
- `HOLD`: any other case, where the state stays the same.

In the memory-mapped use, the data word packs the address, the write data and the write and read strobes, and the valid input is the OR of the two strobes. When `ADAPT` is 0, the block is three plain wires.

Top module: `rl_shrink_adapter`

## Requirements
- R1: While `rst` is high, `snk_ready` and `src_valid` are low, and the store is emptied. `snk_ready` is high in the cycle that follows the first rising edge at which `rst` is low.
- R2: Every beat presented with `snk_valid` high in a cycle after one where `snk_ready` was high is accepted. No beat is lost, even when the consumer stalls at any time.
- R3: A beat leaves only in a cycle where `src_valid` and `src_ready` are both high. A beat that is offered but not taken stays in the block.
- R4: Beats leave in arrival order, each exactly once, with `src_data` equal to the `snk_data` the beat arrived with.
- R5: `snk_ready` in cycle t+1 is high exactly when the number of beats stored after the edge ending cycle t, plus 1 if `snk_ready` was high in cycle t, is at most 1.
- R6: While `src_ready` stays high and the producer offers a beat whenever allowed, `snk_ready` stays high and one beat passes per cycle.
- R7: If `src_valid` is high and `src_ready` is low, then in the next cycle `src_valid` is still high and `src_data` is unchanged.
- R8: `src_valid` is high exactly when the store holds a beat or `snk_valid` is high. With an empty store, the input beat's data appears on `src_data` in the same cycle.
- R9: With `ADAPT` = 0, `src_valid` equals `snk_valid`, `src_data` equals `snk_data` and `snk_ready` equals `src_ready` in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| snk_valid | input | 1 | Beat offered by the producer (ready latency 1) |
| snk_data | input | DATA_W | Beat payload from the producer |
| snk_ready | output | 1 | Registered permission for a beat in the next cycle |
| src_valid | output | 1 | Beat offered to the consumer |
| src_data | output | DATA_W | Beat payload to the consumer |
| src_ready | input | 1 | Consumer accepts in this cycle (ready latency 0) |

## Verification
A fill state that is too low shows up as an early `snk_ready` in the next cycle, followed by an overwritten beat. The scoreboard reports this as a data miscompare within a few cycles. A fill state that is too high shows up in the same cycle as `src_valid` without a beat behind it, or as `snk_ready` held low. A wrong read or write pointer shows up as a beat that is out of order or repeated on the first transfer after a stall. The bench predicts `snk_ready` and `src_valid` each cycle from its own model of the fill level, so a wrong state is caught in the cycle it first affects a port.

// File: rtl/rls_pkg.sv
package rls_pkg;
    // fill level of the absorb store; the encoding equals the beat count
    typedef enum logic [1:0] {
        FILL_NONE = 2'd0,
        FILL_ONE  = 2'd1,
        FILL_TWO  = 2'd2
    } fill_e;

    localparam int SLOTS = 2;
    localparam int PTR_W = $clog2(SLOTS);
endpackage

// File: rtl/rls_store.sv
module rls_store #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_adv,
    output logic [DATA_W-1:0] rd_data
);
    import rls_pkg::*;

    logic [DATA_W-1:0] slot_q [SLOTS];
    logic [PTR_W-1:0]  wp_q;
    logic [PTR_W-1:0]  rp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (wr_en)  wp_q <= wp_q + 1'b1;
            if (rd_adv) rp_q <= rp_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) slot_q[wp_q] <= wr_data;
    end

    assign rd_data = slot_q[rp_q];
endmodule

// File: rtl/rls_ctrl.sv
module rls_ctrl (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          out_ready,
    output logic          in_ready,
    output logic          out_valid,
    output logic          pass_sel,
    output logic          wr_en,
    output logic          rd_adv
);
    import rls_pkg::*;

    fill_e state_q, state_d;
    logic  ready_q, ready_d;
    logic  pop;

    assign pop = out_valid && out_ready;

    // next state: LOAD, FILL, DRAIN or HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_NONE: if (in_valid && !pop)      state_d = FILL_ONE;
            FILL_ONE:  if (in_valid && !pop)      state_d = FILL_TWO;
                       else if (!in_valid && pop) state_d = FILL_NONE;
            FILL_TWO:  if (!in_valid && pop)      state_d = FILL_ONE;
            default:                              state_d = FILL_NONE;
        endcase
        // room for one more beat beyond the one that may still be in flight
        ready_d = (2'(state_d) + {1'b0, ready_q}) <= 2'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FILL_NONE;
            ready_q <= 1'b0;
        end else begin
            state_q <= state_d;
            ready_q <= ready_d;
        end
    end

    always_comb begin
        in_ready  = ready_q;
        pass_sel  = 1'b0;
        out_valid = 1'b1;
        wr_en     = 1'b0;
        rd_adv    = 1'b0;
        unique case (state_q)
            FILL_NONE: begin
                pass_sel  = 1'b1;
                out_valid = in_valid;
                wr_en     = in_valid && !out_ready;
            end
            FILL_ONE: begin
                wr_en  = in_valid;
                rd_adv = out_ready;
            end
            FILL_TWO: begin
                wr_en  = in_valid && out_ready;
                rd_adv = out_ready;
            end
            default: out_valid = 1'b0;
        endcase
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (state_q == FILL_TWO) |-> !in_valid);  // R2
    AST_READY_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        (state_q == FILL_TWO) |-> !ready_q);  // R5
endmodule

// File: rtl/rl_shrink_adapter.sv
module rl_shrink_adapter #(
    parameter int DATA_W = 16,
    parameter bit ADAPT  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              snk_valid,
    input  logic [DATA_W-1:0] snk_data,
    output logic              snk_ready,
    output logic              src_valid,
    output logic [DATA_W-1:0] src_data,
    input  logic              src_ready
);
    generate
        if (ADAPT) begin : g_adapt
            logic              pass_sel;
            logic              wr_en;
            logic              rd_adv;
            logic [DATA_W-1:0] held;

            rls_ctrl u_ctrl (
                .clk       (clk),
                .rst       (rst),
                .in_valid  (snk_valid),
                .out_ready (src_ready),
                .in_ready  (snk_ready),
                .out_valid (src_valid),
                .pass_sel  (pass_sel),
                .wr_en     (wr_en),
                .rd_adv    (rd_adv)
            );

            rls_store #(.DATA_W(DATA_W)) u_store (
                .clk     (clk),
                .rst     (rst),
                .wr_en   (wr_en),
                .wr_data (snk_data),
                .rd_adv  (rd_adv),
                .rd_data (held)
            );

            assign src_data = pass_sel ? snk_data : held;

            AST_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
                (src_valid && !src_ready) |=> (src_valid && $stable(src_data)));  // R7
            AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |=> snk_ready);  // R1
        end else begin : g_wire
            assign src_valid = snk_valid;
            assign src_data  = snk_data;
            assign snk_ready = src_ready;
        end
    endgenerate
endmodule

// File: tb/rl_shrink_adapter_test.sv
module rl_shrink_adapter_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int WW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          snk_valid = 1'b0;
    logic [DW-1:0] snk_data = '0;
    logic          snk_ready;
    logic          src_valid;
    logic [DW-1:0] src_data;
    logic          src_ready = 1'b0;

    logic          w_snk_valid = 1'b0;
    logic [WW-1:0] w_snk_data = '0;
    logic          w_snk_ready;
    logic          w_src_valid;
    logic [WW-1:0] w_src_data;
    logic          w_src_ready = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int n_in  = 0;
    int n_out = 0;
    int seq   = 1;
    logic [DW-1:0] exp_q [$];
    bit  mon_on = 1'b0;
    bit  last_r = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rl_shrink_adapter #(.DATA_W(DW), .ADAPT(1'b1)) uut (
        .clk(clk), .rst(rst), .snk_valid(snk_valid), .snk_data(snk_data),
        .snk_ready(snk_ready), .src_valid(src_valid), .src_data(src_data),
        .src_ready(src_ready));

    rl_shrink_adapter #(.DATA_W(WW), .ADAPT(1'b0)) uut_wire (
        .clk(clk), .rst(rst), .snk_valid(w_snk_valid), .snk_data(w_snk_data),
        .snk_ready(w_snk_ready), .src_valid(w_src_valid), .src_data(w_src_data),
        .src_ready(w_src_ready));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // driver: obeys ready latency 1, pushes each accepted beat as expected
    task automatic drive_cycle(input int pv, input int pr);
        bit allow;
        @(negedge clk);
        allow  = last_r;
        last_r = snk_ready;
        src_ready = ($urandom_range(99) < pr);
        if (allow && ($urandom_range(99) < pv)) begin
            snk_valid = 1'b1;
            snk_data  = DW'(seq);
            exp_q.push_back(DW'(seq));
            seq++;
            n_in++;
        end else begin
            snk_valid = 1'b0;
            snk_data  = DW'($urandom);
        end
    endtask

    // monitor: independent fill model, pops the scoreboard
    int            occ = 0;
    bit            rdy_m = 1'b1;
    bit            stall_p = 1'b0;
    logic [DW-1:0] data_p = '0;
    always @(negedge clk) begin
        #2;
        if (mon_on) begin
            bit pop;
            bit push;
            check(src_valid == ((occ != 0) || snk_valid), "R8 src_valid", src_valid, (occ != 0) || snk_valid);
            check(snk_ready == rdy_m, "R5 snk_ready", snk_ready, rdy_m);
            if (stall_p) begin
                check(src_valid == 1'b1, "R7 valid held", src_valid, 1);
                check(src_data == data_p, "R7 data held", src_data, data_p);
            end
            pop  = src_valid && src_ready;
            push = snk_valid;
            if (pop) begin
                n_out++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 R4 extra beat", src_data, -1);
                end else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    check(src_data == e, "R3 R4 beat order", src_data, e);
                end
            end
            occ     = occ + int'(push) - int'(pop);
            rdy_m   = (occ + int'(rdy_m)) <= 1;
            stall_p = src_valid && !src_ready;
            data_p  = src_data;
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int in0;
        int out0;
        repeat (3) begin
            @(negedge clk);
            #1;
            check(snk_ready == 1'b0, "R1 ready low in reset", snk_ready, 0);
            check(src_valid == 1'b0, "R1 valid low in reset", src_valid, 0);
        end
        rst = 1'b0;
        #1;
        check(snk_ready == 1'b0, "R1 ready before first edge", snk_ready, 0);
        @(negedge clk);
        check(snk_ready == 1'b1, "R1 ready after release", snk_ready, 1);
        last_r = snk_ready;
        mon_on = 1'b1;

        // R6: consumer always ready, producer always offers
        in0 = n_in;
        out0 = n_out;
        repeat (30) drive_cycle(100, 100);
        #3;
        check((n_out - out0) == (n_in - in0), "R6 beats per cycle", n_out - out0, n_in - in0);
        check((n_in - in0) >= 29, "R6 throughput", n_in - in0, 29);

        // random traffic on both sides (R2 R3 R4 R5 R7 R8)
        repeat (600) drive_cycle(70, 50);
        repeat (300) drive_cycle(100, 25);

        // long stall with eager producer, then drain (R2)
        repeat (10) drive_cycle(100, 0);
        #3;
        check(exp_q.size() == 2, "R2 beats held in stall", exp_q.size(), 2);
        repeat (6) drive_cycle(0, 100);
        repeat (3) drive_cycle(0, 100);
        #3;
        check(exp_q.size() == 0, "R2 nothing lost", exp_q.size(), 0);
        check(n_in == n_out, "R2 R4 in equals out", n_out, n_in);
        mon_on = 1'b0;

        // R9: bypass variant
        repeat (16) begin
            @(negedge clk);
            w_snk_valid = 1'($urandom);
            w_snk_data  = WW'($urandom);
            w_src_ready = 1'($urandom);
            #1;
            check(w_src_valid == w_snk_valid, "R9 valid wire", w_src_valid, w_snk_valid);
            check(w_src_data == w_snk_data, "R9 data wire", w_src_data, w_snk_data);
            check(w_snk_ready == w_src_ready, "R9 ready wire", w_snk_ready, w_src_ready);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule